// File: doc/BRIEF.md
# Variable Page Size Translation Lookaside Buffer

This block is a small, fully associative translation buffer. It turns a virtual address into a physical address. A single page-size register covers every entry at once. The register holds a 3-bit code `n`, and that code sets the page offset width to `10 + 2n` bits. The eight codes therefore cover pages from 1 KB up to 16 MB, with each step four times larger than the last. Offset bits are copied straight from the virtual address. Only the bits above the offset are compared against a stored tag and then replaced by the stored physical page number.

Software fills the entries through a write port. Each write carries an index, a 22-bit tag (virtual address bits 31:10), a 22-bit physical page number (physical address bits 31:10) and three attributes: valid, supervisor-only and writable. A lookup presents a virtual address together with a user/supervisor mode bit and a write flag. The registered result appears one clock later. It carries a hit flag, the physical address and a protection-fault flag. When several entries match, the one with the lowest index is used.

Top module: `vps_tlb`

## Requirements
- R1: After reset every entry is invalid, the page-size code is 0 (1 KB pages) and `rsp_valid` is 0, so any lookup made before an entry is written misses.
- R2: A lookup request in cycle t produces `rsp_valid`=1 in cycle t+1. `rsp_valid` is 0 in a cycle that follows a cycle without a request.
- R3: A lookup hits only when a valid entry's tag equals virtual address bits 31:10 in every tag bit `k` with `k >= 2n`. Tag bits below `2n` fall inside the page offset and are ignored.
- R4: On a hit, physical address bits below `10+2n` equal the same bits of the virtual address. The bits at and above `10+2n` come from the entry's physical page number (page-number bit j sits at address bit j+10).
- R5: Page-size code n (0..7) selects 1K, 4K, 16K, 64K, 256K, 1M, 4M or 16M pages, with offset width `10+2n`. A code is loaded while `cfg_we`=1 and governs lookups from the next cycle on. Without `cfg_we` the code holds.
- R6: When several valid entries match, the result uses the entry with the lowest index.
- R7: A hit on a supervisor-only entry while `lk_user`=1 gives `rsp_fault`=1. `rsp_hit` stays 1 and the physical address is still returned. A supervisor access (`lk_user`=0) to the same entry does not fault for that reason.
- R8: A write lookup (`lk_write`=1) that hits an entry whose writable bit is 0 gives `rsp_fault`=1 in both modes. A read of that entry does not fault.
- R9: A miss returns `rsp_hit`=0, `rsp_fault`=0 and a physical address of 0, whatever the mode and write flag.
- R10: An entry write takes effect from the next cycle. A lookup in the same cycle as the write sees the old contents. Writing an entry with valid=0 removes it from matching.
- R11: A lookup in the same cycle as a page-size load uses the old page size.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Load the page-size code |
| cfg_code | input | 3 | New page-size code n (offset width 10+2n) |
| wr_en | input | 1 | Write one entry |
| wr_idx | input | 4 | Entry index to write |
| wr_tag | input | 22 | Virtual page tag, address bits 31:10 |
| wr_ppn | input | 22 | Physical page number, address bits 31:10 |
| wr_valid | input | 1 | Entry valid attribute |
| wr_sup | input | 1 | Entry supervisor-only attribute |
| wr_wen | input | 1 | Entry writable attribute |
| lk_req | input | 1 | Lookup request |
| lk_va | input | 32 | Virtual address to translate |
| lk_user | input | 1 | 1 = user mode, 0 = supervisor mode |
| lk_write | input | 1 | 1 = write access, 0 = read access |
| rsp_valid | output | 1 | Result valid, one cycle after the request |
| rsp_hit | output | 1 | A valid entry matched |
| rsp_pa | output | 32 | Translated physical address, 0 on a miss |
| rsp_fault | output | 1 | Protection fault on a hit |

## Verification
Two pairs of functions can fall in the same cycle. An entry write can coincide with a lookup of that entry, and a page-size load can coincide with a lookup whose outcome depends on the size. The bench provokes both by driving `wr_en` or `cfg_we` together with `lk_req` on one clock edge. It judges the same-cycle response against the old entry or the old size. The lookup in the following cycle must then reflect the new state. Overlapping matches are also forced on purpose, with two entries sharing a tag, and the lower index must win until it is invalidated.

// File: rtl/vps_tlb_pkg.sv
`timescale 1ns/1ps
package vps_tlb_pkg;
  // smallest page offset: 1 KB pages
  localparam int MIN_OFS = 10;
  localparam int SZ_W    = 3;

  typedef enum logic [SZ_W-1:0] {
    PG_1K = 3'd0, PG_4K, PG_16K, PG_64K, PG_256K, PG_1M, PG_4M, PG_16M
  } pg_code_e;

  typedef struct packed {
    logic valid;
    logic sup_only;
    logic writable;
  } tlb_attr_t;

  // offset width in bits for a page-size code
  function automatic int unsigned offset_width(input logic [SZ_W-1:0] code);
    return MIN_OFS + 2 * int'(code);
  endfunction

  // tag bits that fall below the page boundary for a code
  function automatic int unsigned tag_skip(input logic [SZ_W-1:0] code);
    return 2 * int'(code);
  endfunction
endpackage

// File: rtl/vps_tlb_store.sv
`timescale 1ns/1ps
module vps_tlb_store
  import vps_tlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int TAG_W   = 22,
  parameter int PPN_W   = 22,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [IDX_W-1:0]              wr_idx,
  input  logic [TAG_W-1:0]              wr_tag,
  input  logic [PPN_W-1:0]              wr_ppn,
  input  tlb_attr_t                     wr_attr,
  output logic [ENTRIES-1:0][TAG_W-1:0] tags_o,
  output logic [ENTRIES-1:0][PPN_W-1:0] ppns_o,
  output tlb_attr_t [ENTRIES-1:0]       attrs_o
);
  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    logic sel_w;
    assign sel_w = wr_en && (wr_idx == IDX_W'(e));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tags_o[e]  <= '0;
        ppns_o[e]  <= '0;
        attrs_o[e] <= '0;
      end else if (sel_w) begin
        tags_o[e]  <= wr_tag;
        ppns_o[e]  <= wr_ppn;
        attrs_o[e] <= wr_attr;
      end
    end
  end
endmodule

// File: rtl/vps_tlb_match.sv
`timescale 1ns/1ps
module vps_tlb_match
  import vps_tlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int TAG_W   = 22,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0][TAG_W-1:0] tags_i,
  input  tlb_attr_t [ENTRIES-1:0]       attrs_i,
  input  logic [TAG_W-1:0]              va_tag,
  input  logic [SZ_W-1:0]               code,
  output logic [ENTRIES-1:0]            hit_vec,
  output logic                          any_hit,
  output logic [IDX_W-1:0]              sel_idx
);
  // ones on tag bits that sit above the page boundary
  function automatic logic [TAG_W-1:0] cmp_mask(input logic [SZ_W-1:0] c);
    return ~((TAG_W'(1) << tag_skip(c)) - TAG_W'(1));
  endfunction

  logic [TAG_W-1:0] mask_w;
  assign mask_w = cmp_mask(code);

  for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
    assign hit_vec[e] = attrs_i[e].valid &&
                        (((tags_i[e] ^ va_tag) & mask_w) == '0);
  end

  assign any_hit = |hit_vec;

  // lowest index wins
  always_comb begin
    sel_idx = '0;
    for (int e = ENTRIES - 1; e >= 0; e--) begin
      if (hit_vec[e]) sel_idx = IDX_W'(e);
    end
  end
endmodule

// File: rtl/vps_tlb.sv
`timescale 1ns/1ps
module vps_tlb
  import vps_tlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int TAG_W  = VA_W - MIN_OFS,
  localparam int PPN_W  = PA_W - MIN_OFS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [SZ_W-1:0]  cfg_code,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [PPN_W-1:0] wr_ppn,
  input  logic             wr_valid,
  input  logic             wr_sup,
  input  logic             wr_wen,
  input  logic             lk_req,
  input  logic [VA_W-1:0]  lk_va,
  input  logic             lk_user,
  input  logic             lk_write,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic [PA_W-1:0]  rsp_pa,
  output logic             rsp_fault
);
  // physical address: page number above the offset, VA bits inside it
  function automatic logic [PA_W-1:0] join_pa(input logic [PPN_W-1:0] ppn,
                                              input logic [VA_W-1:0]  va,
                                              input logic [SZ_W-1:0]  c);
    logic [PA_W-1:0] low_m;
    low_m = (PA_W'(1) << offset_width(c)) - PA_W'(1);
    return ({ppn, {MIN_OFS{1'b0}}} & ~low_m) | (PA_W'(va) & low_m);
  endfunction

  // page-size register
  logic [SZ_W-1:0] sz_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sz_q <= PG_1K;
    else if (cfg_we) sz_q <= cfg_code;
  end

  // entry storage
  logic [ENTRIES-1:0][TAG_W-1:0] tags;
  logic [ENTRIES-1:0][PPN_W-1:0] ppns;
  tlb_attr_t [ENTRIES-1:0]       attrs;
  tlb_attr_t                     wr_attr;
  assign wr_attr = '{valid: wr_valid, sup_only: wr_sup, writable: wr_wen};

  vps_tlb_store #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .PPN_W(PPN_W)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_tag(wr_tag), .wr_ppn(wr_ppn), .wr_attr(wr_attr),
    .tags_o(tags), .ppns_o(ppns), .attrs_o(attrs)
  );

  // associative compare, visible to the checker
  logic [ENTRIES-1:0] hit_vec;
  logic               any_hit;
  logic [IDX_W-1:0]   sel_idx;

  vps_tlb_match #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_match (
    .tags_i(tags), .attrs_i(attrs), .va_tag(lk_va[VA_W-1:MIN_OFS]),
    .code(sz_q), .hit_vec(hit_vec), .any_hit(any_hit), .sel_idx(sel_idx)
  );

  tlb_attr_t       sel_attr;
  logic            fault_now;
  logic [PA_W-1:0] pa_now;
  assign sel_attr  = attrs[sel_idx];
  assign fault_now = any_hit && ((lk_user && sel_attr.sup_only) ||
                                 (lk_write && !sel_attr.writable));
  assign pa_now    = any_hit ? join_pa(ppns[sel_idx], lk_va, sz_q) : '0;

  // registered response
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_pa    <= '0;
      rsp_fault <= 1'b0;
    end else begin
      rsp_valid <= lk_req;
      if (lk_req) begin
        rsp_hit   <= any_hit;
        rsp_pa    <= pa_now;
        rsp_fault <= fault_now;
      end
    end
  end
endmodule

// File: rtl/vps_tlb_chk.sv
`timescale 1ns/1ps
module vps_tlb_chk
  import vps_tlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int PA_W    = 32,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cfg_we,
  input logic               lk_req,
  input logic [MIN_OFS-1:0] lk_ofs,
  input logic               rsp_valid,
  input logic               rsp_hit,
  input logic [PA_W-1:0]    rsp_pa,
  input logic               rsp_fault,
  input logic [ENTRIES-1:0] hit_vec,
  input logic               any_hit,
  input logic [IDX_W-1:0]   sel_idx,
  input logic [SZ_W-1:0]    sz_q
);
  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n) lk_req |=> rsp_valid); // R2
  AST_RSP_ONLY_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n) !lk_req |=> !rsp_valid); // R2
  AST_NO_MATCH_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n) (lk_req && hit_vec == '0) |=> !rsp_hit); // R3
  AST_OFFSET_PASSES: assert property (@(posedge clk) disable iff (!rst_n) lk_req |=> (!rsp_hit || rsp_pa[MIN_OFS-1:0] == $past(lk_ofs))); // R4
  AST_SIZE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) !cfg_we |=> $stable(sz_q)); // R5
  AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (!rst_n) any_hit |-> (hit_vec[sel_idx] && ((hit_vec & ((ENTRIES'(1) << sel_idx) - ENTRIES'(1))) == '0))); // R6
  AST_FAULT_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n) rsp_fault |-> rsp_hit); // R7
  AST_MISS_IS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n) (rsp_valid && !rsp_hit) |-> (!rsp_fault && rsp_pa == '0)); // R9
endmodule

bind vps_tlb vps_tlb_chk #(.ENTRIES(ENTRIES), .PA_W(PA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .lk_req(lk_req),
  .lk_ofs(lk_va[vps_tlb_pkg::MIN_OFS-1:0]), .rsp_valid(rsp_valid),
  .rsp_hit(rsp_hit), .rsp_pa(rsp_pa), .rsp_fault(rsp_fault),
  .hit_vec(hit_vec), .any_hit(any_hit), .sel_idx(sel_idx), .sz_q(sz_q)
);

// File: tb/sim_vps_tlb.sv
`timescale 1ns/1ps
module sim_vps_tlb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_code = '0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_idx = '0;
  logic [21:0] wr_tag = '0;
  logic [21:0] wr_ppn = '0;
  logic        wr_valid = 1'b0, wr_sup = 1'b0, wr_wen = 1'b0;
  logic        lk_req = 1'b0;
  logic [31:0] lk_va = '0;
  logic        lk_user = 1'b0, lk_write = 1'b0;
  logic        rsp_valid, rsp_hit, rsp_fault;
  logic [31:0] rsp_pa;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  vps_tlb u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_code(cfg_code),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag), .wr_ppn(wr_ppn),
    .wr_valid(wr_valid), .wr_sup(wr_sup), .wr_wen(wr_wen),
    .lk_req(lk_req), .lk_va(lk_va), .lk_user(lk_user), .lk_write(lk_write),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_pa(rsp_pa), .rsp_fault(rsp_fault)
  );

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // every task starts and ends just after a falling edge
  task automatic put_entry(input int idx, input logic [21:0] tag, input logic [21:0] ppn,
                           input logic v, input logic s, input logic w);
    wr_en = 1'b1; wr_idx = 4'(idx); wr_tag = tag; wr_ppn = ppn;
    wr_valid = v; wr_sup = s; wr_wen = w;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_size(input int code);
    cfg_we = 1'b1; cfg_code = 3'(code);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic look(input logic [31:0] va, input logic user, input logic wr);
    lk_req = 1'b1; lk_va = va; lk_user = user; lk_write = wr;
    @(negedge clk);
    lk_req = 1'b0;
  endtask

  task automatic expect_rsp(input string req, input logic hit,
                            input logic [31:0] pa, input logic flt);
    chk(req, "rsp_valid", 64'(rsp_valid), 64'(1'b1));
    chk(req, "rsp_hit",   64'(rsp_hit),   64'(hit));
    chk(req, "rsp_pa",    64'(rsp_pa),    64'(pa));
    chk(req, "rsp_fault", 64'(rsp_fault), 64'(flt));
  endtask

  task automatic t_reset();
    chk("R1", "rsp_valid after reset", 64'(rsp_valid), 64'd0);
    look(32'h0000_0000, 1'b0, 1'b0);
    expect_rsp("R1", 1'b0, 32'h0, 1'b0);
    look(32'hFFFF_FC00, 1'b1, 1'b1);
    expect_rsp("R1", 1'b0, 32'h0, 1'b0);
  endtask

  task automatic t_basic();
    put_entry(3, 22'h12345, 22'h0ABCD, 1'b1, 1'b0, 1'b1);
    look({22'h12345, 10'h155}, 1'b0, 1'b0);
    expect_rsp("R3", 1'b1, {22'h0ABCD, 10'h155}, 1'b0);
    @(negedge clk);
    chk("R2", "rsp_valid idle cycle", 64'(rsp_valid), 64'd0);
    look({22'h12345, 10'h2AA}, 1'b1, 1'b1);
    expect_rsp("R4", 1'b1, {22'h0ABCD, 10'h2AA}, 1'b0);
  endtask

  task automatic t_sizes();
    logic [21:0] tag = 22'h12345;
    logic [21:0] ppn = 22'h0ABCD;
    look({22'h12344, 10'h155}, 1'b0, 1'b0);
    expect_rsp("R3", 1'b0, 32'h0, 1'b0);
    for (int n = 0; n < 8; n++) begin
      logic [31:0] va;
      logic [31:0] pa;
      int ow;
      ow = 10 + 2 * n;
      set_size(n);
      // flipping tag bit 2n lies above the offset: miss
      va = {tag ^ (22'd1 << (2 * n)), 10'h0F0};
      look(va, 1'b0, 1'b0);
      expect_rsp("R5", 1'b0, 32'h0, 1'b0);
      if (n > 0) begin
        // flipping tag bit 2n-1 lies inside the offset: hit
        va = {tag ^ (22'd1 << (2 * n - 1)), 10'h30F};
        pa = 32'h0;
        for (int b = 0; b < 32; b++)
          pa[b] = (b < ow) ? va[b] : ppn[b - 10];
        look(va, 1'b0, 1'b0);
        expect_rsp("R5", 1'b1, pa, 1'b0);
      end
    end
    // 16 MB pages: only VA bits 31:24 matter
    look({8'h04, 24'hABCDEF}, 1'b0, 1'b0);
    expect_rsp("R4", 1'b1, {8'h02, 24'hABCDEF}, 1'b0);
    look({8'h05, 24'hABCDEF}, 1'b0, 1'b0);
    expect_rsp("R3", 1'b0, 32'h0, 1'b0);
  endtask

  task automatic t_priority();
    set_size(0);
    put_entry(9, 22'h00777, 22'h22222, 1'b1, 1'b0, 1'b1);
    put_entry(5, 22'h00777, 22'h11111, 1'b1, 1'b0, 1'b1);
    look({22'h00777, 10'h001}, 1'b0, 1'b0);
    expect_rsp("R6", 1'b1, {22'h11111, 10'h001}, 1'b0);
    put_entry(5, 22'h00777, 22'h11111, 1'b0, 1'b0, 1'b1);
    look({22'h00777, 10'h001}, 1'b0, 1'b0);
    expect_rsp("R10", 1'b1, {22'h22222, 10'h001}, 1'b0);
  endtask

  task automatic t_protect();
    put_entry(12, 22'h3FF00, 22'h00042, 1'b1, 1'b1, 1'b0);
    put_entry(13, 22'h3FF01, 22'h00043, 1'b1, 1'b0, 1'b1);
    put_entry(14, 22'h3FF02, 22'h00044, 1'b1, 1'b0, 1'b0);
    look({22'h3FF00, 10'h010}, 1'b1, 1'b0);
    expect_rsp("R7", 1'b1, {22'h00042, 10'h010}, 1'b1);
    look({22'h3FF00, 10'h010}, 1'b0, 1'b0);
    expect_rsp("R7", 1'b1, {22'h00042, 10'h010}, 1'b0);
    look({22'h3FF00, 10'h010}, 1'b0, 1'b1);
    expect_rsp("R8", 1'b1, {22'h00042, 10'h010}, 1'b1);
    look({22'h3FF01, 10'h020}, 1'b1, 1'b1);
    expect_rsp("R8", 1'b1, {22'h00043, 10'h020}, 1'b0);
    look({22'h3FF02, 10'h030}, 1'b1, 1'b0);
    expect_rsp("R8", 1'b1, {22'h00044, 10'h030}, 1'b0);
    look({22'h3FF02, 10'h030}, 1'b1, 1'b1);
    expect_rsp("R8", 1'b1, {22'h00044, 10'h030}, 1'b1);
  endtask

  task automatic t_miss();
    look({22'h2AAAA, 10'h3FF}, 1'b1, 1'b1);
    expect_rsp("R9", 1'b0, 32'h0, 1'b0);
  endtask

  task automatic t_same_write();
    // write and lookup on the same edge
    wr_en = 1'b1; wr_idx = 4'd3; wr_tag = 22'h12345; wr_ppn = 22'h05555;
    wr_valid = 1'b1; wr_sup = 1'b0; wr_wen = 1'b1;
    look({22'h12345, 10'h077}, 1'b0, 1'b0);
    wr_en = 1'b0;
    expect_rsp("R10", 1'b1, {22'h0ABCD, 10'h077}, 1'b0);
    look({22'h12345, 10'h077}, 1'b0, 1'b0);
    expect_rsp("R10", 1'b1, {22'h05555, 10'h077}, 1'b0);
  endtask

  task automatic t_same_size();
    // size load and lookup on the same edge: old 1 KB size applies
    cfg_we = 1'b1; cfg_code = 3'd7;
    look({22'h12000, 10'h000}, 1'b0, 1'b0);
    cfg_we = 1'b0;
    expect_rsp("R11", 1'b0, 32'h0, 1'b0);
    look({22'h12000, 10'h000}, 1'b0, 1'b0);
    expect_rsp("R11", 1'b1, {8'h01, 24'h800000}, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_sizes();
    t_priority();
    t_protect();
    t_miss();
    t_same_write();
    t_same_size();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule